// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog timer behind one memory-mapped control word. Software must prove it is alive by restarting the time-out count before the count expires. If the count expires, the block either asserts a system reset for a fixed stretch or raises a non-maskable interrupt request. Flag bits in the control word record which kind of event happened, so start-up code or an interrupt handler can tell a watchdog event from other causes. A configuration write lands only when a two-word unlock key comes directly before it. A separate two-word key restarts the count without touching the configuration. A read of the control word throws away any key entered so far.

The design has two state machines and a counter. The key decoder has the states `KS_IDLE`, `KS_UNLK1`, `KS_OPEN` and `KS_CLR1`. It moves from `KS_IDLE` to `KS_UNLK1` on 0x3333, from `KS_UNLK1` to `KS_OPEN` on 0xCCCC, and from `KS_OPEN` back to `KS_IDLE` on the data write, which it commits. It moves from `KS_IDLE` to `KS_CLR1` on 0xAAAA, and from `KS_CLR1` back to `KS_IDLE` on any write, which restarts the count when the word is 0x5555. Any other word, and any read, returns it to `KS_IDLE`.

The reset sequencer has the states `RS_RUN`, `RS_WDOG` and `RS_EXT`. A time-out in reset mode moves it from `RS_RUN` to `RS_WDOG`, where it holds the reset for 2^HOLD_EXP cycles before returning to `RS_RUN`. The external reset input forces it into `RS_EXT` from any state. It stays there until the input has been low for EXT_TAIL cycles, then returns to `RS_RUN`.

Top module: `wdt_ctrl`

## Requirements
- R1: After the external reset, the control word reads 0x001D and nmi_o is low. Field layout: bit 0 enable, bit 1 mode (1 = NMI, 0 = reset), bits 4:2 time-out select, bit 14 NMI flag, bit 15 reset flag.
- R2: A write to the control address is committed only when it directly follows the writes 0x3333 and then 0xCCCC. The key words themselves are never stored. A committed write also restarts the count.
- R3: Any word other than the expected next key returns the key decoder to idle, so a data write that follows a broken or reordered key leaves the control word unchanged.
- R4: A read of the control address cancels a key that is partly or fully entered, so the next data write is ignored.
- R5: The first committed write after any reset may set or clear the enable bit. After that, a committed write can set enable but cannot clear it. While enable is 0 no time-out occurs.
- R6: With enable set, a time-out occurs P = 2^(BASE_EXP + 2·sel) cycles after the count last restarted. In reset mode, sys_rst_o is then high for exactly 2^HOLD_EXP cycles, and afterwards the configuration reads back at its reset values.
- R7: In NMI mode, a time-out sets the NMI flag and nmi_o, which follows the flag. Both stay set until a committed write with bit 14 = 1 clears them.
- R8: The key 0xAAAA followed by 0x5555 restarts the count without changing the configuration.
- R9: The external reset input overrides a watchdog reset in progress. It leaves the reset flag clear, and sys_rst_o falls EXT_TAIL cycles after the input is seen low.
- R10: The reset flag survives the watchdog reset it records. A committed write with bit 15 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| ext_rst_i | input | 1 | External reset, synchronous, active high |
| addr_i | input | ADDR_W | Register bus address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while the read strobe hits the control address, else 0 |
| nmi_o | output | 1 | Non-maskable interrupt request (level) |
| sys_rst_o | output | 1 | System reset output |

## Verification
A key decoder left in the wrong state shows on the very next data write. The control word that comes back on the following read either changed when it should have stayed the same, or stayed the same when it should have changed. A wrong count or a wrong select decode moves the edge of sys_rst_o or nmi_o, and the bench counts the cycles to that edge exactly. A fault in the sequencer changes how many cycles sys_rst_o stays high. A fault in the flag logic shows in bits 15:14 on the first read after the event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW       = 16;
    localparam int SEL_W    = 3;
    localparam int EN_BIT   = 0;
    localparam int MODE_BIT = 1;
    localparam int SEL_LSB  = 2;
    localparam int NMIF_BIT = 14;
    localparam int RSTF_BIT = 15;

    localparam logic [DW-1:0] UNLK_A = 16'h3333;
    localparam logic [DW-1:0] UNLK_B = 16'hCCCC;
    localparam logic [DW-1:0] CLR_A  = 16'hAAAA;
    localparam logic [DW-1:0] CLR_B  = 16'h5555;

    typedef enum logic [1:0] {KS_IDLE, KS_UNLK1, KS_OPEN, KS_CLR1} key_st_e;
    typedef enum logic [1:0] {RS_RUN, RS_WDOG, RS_EXT} seq_st_e;
endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          wr_hit_i,
    input  logic          rd_hit_i,
    input  logic [DW-1:0] wdata_i,
    output logic          commit_o,
    output logic          restart_o
);
    key_st_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (clr_i) st_q <= KS_IDLE;
        else       st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (rd_hit_i) begin
            st_d = KS_IDLE;
        end else if (wr_hit_i) begin
            unique case (st_q)
                KS_IDLE:  st_d = (wdata_i == UNLK_A) ? KS_UNLK1 :
                                 (wdata_i == CLR_A)  ? KS_CLR1  : KS_IDLE;
                KS_UNLK1: st_d = (wdata_i == UNLK_B) ? KS_OPEN : KS_IDLE;
                KS_OPEN:  st_d = KS_IDLE;
                KS_CLR1:  st_d = KS_IDLE;
                default:  st_d = KS_IDLE;
            endcase
        end
    end

    always_comb begin
        commit_o  = wr_hit_i && !rd_hit_i && (st_q == KS_OPEN);
        restart_o = wr_hit_i && !rd_hit_i && (st_q == KS_CLR1) && (wdata_i == CLR_B);
    end
endmodule

// File: rtl/wdt_tick_cnt.sv
module wdt_tick_cnt
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 12
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             fire_o
);
    localparam int MAX_EXP = BASE_EXP + 2 * ((1 << SEL_W) - 1);
    localparam int SHW     = $clog2(MAX_EXP + 1);

    logic [MAX_EXP-1:0] cnt_q;
    logic [SHW-1:0]     shamt;
    logic [MAX_EXP:0]   span;

    always_comb begin
        shamt  = SHW'(BASE_EXP) + SHW'({sel_i, 1'b0});
        span   = (MAX_EXP+1)'(1) << shamt;
        fire_o = run_i && !clr_i && ({1'b0, cnt_q} == span - 1'b1);
    end

    always_ff @(posedge clk_i) begin
        if (clr_i || fire_o) cnt_q <= '0;
        else if (run_i)      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq
    import wdt_pkg::*;
#(
    parameter int HOLD_EXP = 16,
    parameter int EXT_TAIL = 4
) (
    input  logic clk_i,
    input  logic ext_rst_i,
    input  logic wd_fire_i,
    output logic in_rst_o,
    output logic wd_hold_o
);
    localparam int TAIL_W = $clog2(EXT_TAIL + 1);
    localparam int CW     = (HOLD_EXP > TAIL_W) ? HOLD_EXP : TAIL_W;

    seq_st_e       st_q, st_d;
    logic [CW-1:0] seq_q;

    always_ff @(posedge clk_i) begin
        if (ext_rst_i) st_q <= RS_EXT;
        else           st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (ext_rst_i || (st_q != st_d)) seq_q <= '0;
        else                             seq_q <= seq_q + 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_RUN:  if (wd_fire_i) st_d = RS_WDOG;
            RS_WDOG: if (seq_q == CW'({HOLD_EXP{1'b1}})) st_d = RS_RUN;
            RS_EXT:  if (seq_q == CW'(EXT_TAIL - 1)) st_d = RS_RUN;
            default: st_d = RS_EXT;
        endcase
    end

    always_comb begin
        in_rst_o  = (st_q != RS_RUN);
        wd_hold_o = (st_q == RS_WDOG);
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter int              BASE_EXP  = 12,
    parameter int              HOLD_EXP  = 16,
    parameter int              EXT_TAIL  = 4
) (
    input  logic              clk_i,
    input  logic              ext_rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              nmi_o,
    output logic              sys_rst_o
);
    logic             wr_hit, rd_hit, commit, restart, fire;
    logic             in_rst, wd_hold, core_rst, wd_fire, nmi_fire;
    logic             en_q, nmi_mode_q, nmi_flag_q, rst_flag_q, locked_q;
    logic [SEL_W-1:0] sel_q;

    assign wr_hit   = wr_en_i && (addr_i == CTRL_ADDR);
    assign rd_hit   = rd_en_i && (addr_i == CTRL_ADDR);
    assign core_rst = ext_rst_i || in_rst;
    assign wd_fire  = fire && !nmi_mode_q;
    assign nmi_fire = fire && nmi_mode_q;

    wdt_key_fsm u_key (
        .clk_i    (clk_i),
        .clr_i    (core_rst),
        .wr_hit_i (wr_hit),
        .rd_hit_i (rd_hit),
        .wdata_i  (wdata_i),
        .commit_o (commit),
        .restart_o(restart)
    );

    wdt_tick_cnt #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk_i (clk_i),
        .clr_i (core_rst || commit || restart),
        .run_i (en_q),
        .sel_i (sel_q),
        .fire_o(fire)
    );

    wdt_rst_seq #(.HOLD_EXP(HOLD_EXP), .EXT_TAIL(EXT_TAIL)) u_seq (
        .clk_i    (clk_i),
        .ext_rst_i(ext_rst_i),
        .wd_fire_i(wd_fire),
        .in_rst_o (in_rst),
        .wd_hold_o(wd_hold)
    );

    always_ff @(posedge clk_i) begin
        if (ext_rst_i || wd_fire) begin
            en_q       <= 1'b1;
            nmi_mode_q <= 1'b0;
            sel_q      <= '1;
            nmi_flag_q <= 1'b0;
            locked_q   <= 1'b0;
            rst_flag_q <= !ext_rst_i;
        end else begin
            if (commit) begin
                locked_q   <= 1'b1;
                en_q       <= (locked_q && en_q) || wdata_i[EN_BIT];
                nmi_mode_q <= wdata_i[MODE_BIT];
                sel_q      <= wdata_i[SEL_LSB +: SEL_W];
                if (wdata_i[RSTF_BIT]) rst_flag_q <= 1'b0;
            end
            nmi_flag_q <= (nmi_flag_q && !(commit && wdata_i[NMIF_BIT])) || nmi_fire;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_hit) begin
            rdata_o[EN_BIT]              = en_q;
            rdata_o[MODE_BIT]            = nmi_mode_q;
            rdata_o[SEL_LSB +: SEL_W]    = sel_q;
            rdata_o[NMIF_BIT]            = nmi_flag_q;
            rdata_o[RSTF_BIT]            = rst_flag_q;
        end
    end

    assign nmi_o     = nmi_flag_q;
    assign sys_rst_o = ext_rst_i || in_rst;
endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk (
    input logic clk_i,
    input logic ext_rst_i,
    input logic sys_rst_o,
    input logic nmi_o,
    input logic en_q,
    input logic locked_q,
    input logic nmi_mode_q,
    input logic rst_flag_q,
    input logic wd_hold
);
    // R5
    en_sticky_chk: assert property (@(posedge clk_i) disable iff (ext_rst_i)
        (locked_q && en_q && !wd_hold) |=> en_q);

    // R7
    nmi_mode_only_chk: assert property (@(posedge clk_i) disable iff (ext_rst_i)
        $rose(nmi_o) |-> nmi_mode_q);

    // R10
    rst_flag_cause_chk: assert property (@(posedge clk_i) disable iff (ext_rst_i)
        $rose(rst_flag_q) |-> (wd_hold && sys_rst_o));

    // R9
    ext_tail_chk: assert property (@(posedge clk_i) disable iff (ext_rst_i)
        $fell(ext_rst_i) |-> (sys_rst_o && !rst_flag_q));

    // R1
    ext_defaults_chk: assert property (@(posedge clk_i) disable iff (ext_rst_i)
        $fell(ext_rst_i) |-> (en_q && !nmi_mode_q && !nmi_o));
endmodule

bind wdt_ctrl wdt_ctrl_chk u_chk (
    .clk_i     (clk_i),
    .ext_rst_i (ext_rst_i),
    .sys_rst_o (sys_rst_o),
    .nmi_o     (nmi_o),
    .en_q      (en_q),
    .locked_q  (locked_q),
    .nmi_mode_q(nmi_mode_q),
    .rst_flag_q(rst_flag_q),
    .wd_hold   (wd_hold)
);

// File: tb/test_wdt_ctrl.sv
module test_wdt_ctrl;
    localparam int EXT_TAIL = 4;
    localparam int HOLD_EXP = 3;

    logic        clk = 1'b0;
    logic        ext_rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        nmi, sys_rst;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = !clk;

    wdt_ctrl #(.BASE_EXP(2), .HOLD_EXP(HOLD_EXP), .EXT_TAIL(EXT_TAIL)) i_wdt_ctrl (
        .clk_i(clk), .ext_rst_i(ext_rst), .addr_i(addr), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .nmi_o(nmi),
        .sys_rst_o(sys_rst)
    );

    // rows: key0, key1, data, read between key1 and data, expected readback (R2 R3 R4)
    localparam logic [64:0] VEC [0:5] = '{
        {16'h3333, 16'hCCCC, 16'h000D, 1'b0, 16'h000D},
        {16'h3333, 16'h1234, 16'h0001, 1'b0, 16'h000D},
        {16'h3333, 16'hCCCC, 16'h0003, 1'b1, 16'h000D},
        {16'h3333, 16'hCCCC, 16'h000F, 1'b0, 16'h000F},
        {16'hCCCC, 16'h3333, 16'h0001, 1'b0, 16'h000F},
        {16'h3333, 16'hCCCC, 16'h001D, 1'b0, 16'h001D}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] d);
        wr_en = 1'b1; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(output logic [15:0] d);
        rd_en = 1'b1;
        #2 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic keyed_wr(input logic [15:0] d);
        bus_wr(16'h3333); bus_wr(16'hCCCC); bus_wr(d);
    endtask

    task automatic cycles_until(input logic want_rst, input logic lvl, output int n);
        n = 0;
        while (((want_rst ? sys_rst : nmi) != lvl) && n < 100000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [15:0] r;
        int n;
        repeat (5) @(posedge clk);
        #1 ext_rst = 1'b0;
        cycles_until(1'b1, 1'b0, n);
        chk(n == EXT_TAIL, "R9 release after ext reset", n, EXT_TAIL);
        bus_rd(r);
        chk(r == 16'h001D, "R1 reset value", r, 16'h001D);
        chk(nmi == 1'b0, "R1 nmi low", nmi, 0);

        // R5: first write may disable; later writes cannot clear enable
        keyed_wr(16'h0000);
        bus_rd(r);
        chk(r == 16'h0000, "R5 first write clears enable", r, 0);
        repeat (30) @(posedge clk);
        #1 chk(!sys_rst && !nmi, "R5 disabled no timeout", {sys_rst, nmi}, 0);
        keyed_wr(16'h0015);
        bus_rd(r);
        chk(r == 16'h0015, "R5 enable set later", r, 16'h0015);
        keyed_wr(16'h0014);
        bus_rd(r);
        chk(r == 16'h0015, "R5 enable stays set", r, 16'h0015);

        for (int i = 0; i < 6; i++) begin
            logic [64:0] v;
            v = VEC[i];
            bus_wr(v[64:49]);
            bus_wr(v[48:33]);
            if (v[16]) bus_rd(r);
            bus_wr(v[32:17]);
            bus_rd(r);
            chk(r == v[15:0], $sformatf("key table row %0d (R2 R3 R4)", i), r, v[15:0]);
        end

        // R6: reset mode, sel 0 -> 4 cycles; hold 8 cycles
        keyed_wr(16'h0001);
        cycles_until(1'b1, 1'b1, n);
        chk(n == 4, "R6 time-out period sel0", n, 4);
        cycles_until(1'b1, 1'b0, n);
        chk(n == (1 << HOLD_EXP), "R6 reset hold length", n, 1 << HOLD_EXP);
        bus_rd(r);
        chk(r == 16'h801D, "R6 R10 defaults with reset flag", r, 16'h801D);
        keyed_wr(16'h801D);
        bus_rd(r);
        chk(r == 16'h001D, "R10 reset flag cleared", r, 16'h001D);

        // R7: NMI mode, sel 1 -> 16 cycles
        keyed_wr(16'h0007);
        cycles_until(1'b0, 1'b1, n);
        chk(n == 16, "R7 nmi after period sel1", n, 16);
        repeat (20) @(posedge clk);
        #1 chk(nmi && !sys_rst, "R7 nmi held, no reset", {nmi, sys_rst}, 2);
        bus_rd(r);
        chk(r == 16'h4007, "R7 nmi flag readback", r, 16'h4007);
        keyed_wr(16'h401D);
        bus_rd(r);
        chk(r == 16'h001D && !nmi, "R7 nmi flag cleared", r, 16'h001D);

        // R8: restart key delays time-out, sel 2 -> 64 cycles
        keyed_wr(16'h0009);
        repeat (40) @(posedge clk);
        #1;
        bus_wr(16'hAAAA);
        bus_wr(16'h5555);
        chk(!sys_rst, "R8 no reset before restart", sys_rst, 0);
        cycles_until(1'b1, 1'b1, n);
        chk(n == 64, "R8 full period after restart", n, 64);

        // R9: external reset during watchdog hold
        repeat (2) @(posedge clk);
        #1 ext_rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 ext_rst = 1'b0;
        cycles_until(1'b1, 1'b0, n);
        chk(n == EXT_TAIL, "R9 release follows external timing", n, EXT_TAIL);
        bus_rd(r);
        chk(r == 16'h001D, "R9 reset flag not set", r, 16'h001D);

        summary();
    end
endmodule